// File: doc/BRIEF.md
# Code-Origin SPI Access Gate

This block stands between a CPU memory bus and a small SPI master. It decides whether the SPI master may be used by looking at where the running program comes from, not at the address being accessed. Each valid instruction fetch updates a privilege flag that records whether the fetch address lies in the boot ROM region. The loads and stores that follow use that held flag.

While the flag is clear, the register interface of the SPI master is hidden. Writes are acknowledged and dropped. Reads return zero, including the ready status, so unprivileged code cannot find out that an SPI master exists. The external SPI pins are also forced to their idle levels, and the input line toward the master is tied low. The master itself is a simple register-mapped stub that shifts one byte per transfer, in SPI mode 0, MSB first.

Top module: `spigate_top`

## Requirements
- R1: On a cycle where `cpuValid` and `cpuInstr` are both high, the privilege flag is loaded with (`cpuAddr[31:30]` == `ROM_PREFIX`, default 2'b00), and it takes effect from the next cycle. A cycle in which only one of the two is high does not change the flag.
- R2: The privilege flag is set after reset. Data cycles (`cpuValid` high, `cpuInstr` low) leave it unchanged, whatever their address.
- R3: Every API access (`apiCs` high for one cycle) is answered with `apiReady` high in the following cycle, whether the access is granted or not. Read data is valid in that same cycle.
- R4: A granted write to offset 1 stores bit 0 as the select-enable bit. While this bit is 1 and access is granted, `spiCsN` is low. The stored value reads back at offset 1.
- R5: A write made while access is denied is discarded. After the grant returns, offset 1 still holds its earlier value.
- R6: A read made while access is denied returns all zeros. This includes the ready bit (bit 0 of offset 0), which otherwise reads 1 when the master is idle.
- R7: While access is denied, `spiCsN` is 1 and `spiSclk` and `spiMosi` are 0, and the master receives 0 in place of `spiMiso`. A byte shifted in during that time therefore reads back as 0x00 at offset 3.
- R8: A granted write to offset 2 while idle starts an 8-bit transfer with 8 `spiSclk` pulses. `spiMosi` carries the written byte MSB first, valid at each rising edge. `spiMiso` is shifted in MSB first, and the result reads back at offset 3. The ready bit reads 0 while the transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU bus cycle active |
| cpuInstr | input | 1 | Current cycle is an instruction fetch |
| cpuAddr | input | 32 | CPU bus address |
| apiCs | input | 1 | Select for the SPI register window, one cycle per access |
| apiWe | input | 1 | Write when high, read when low |
| apiAddr | input | 2 | Register offset (0 status, 1 select enable, 2 transmit, 3 receive) |
| apiWrData | input | 32 | Write data |
| apiRdData | output | 32 | Read data, valid with apiReady |
| apiReady | output | 1 | Access acknowledge |
| spiCsN | output | 1 | Chip select to the slave, active low |
| spiSclk | output | 1 | Serial clock to the slave |
| spiMosi | output | 1 | Serial data to the slave |
| spiMiso | input | 1 | Serial data from the slave |

## Verification
The assertions assume that `apiCs` pulses last a single cycle and that `apiAddr` and `apiWe` are stable while `apiCs` is high. The directed tasks drive every access as a one-cycle pulse on a falling edge and release it on the next falling edge, so these assumptions always hold. The assertions also assume that any write to offset 2 made during a transfer may simply be ignored. The bench starts a new transfer only after waiting longer than the 16 cycles a byte takes. Instruction fetches and data cycles are driven as separate one-cycle pulses. The single exception is the case that joins a transfer start with a RAM fetch in the same cycle, which is there to revoke the grant exactly at the first sample.

// File: rtl/spigate_pkg.sv
package spigate_pkg;
  localparam int OFF_W = 2;
  localparam logic [OFF_W-1:0] OFF_STATUS = 2'd0;
  localparam logic [OFF_W-1:0] OFF_SELECT = 2'd1;
  localparam logic [OFF_W-1:0] OFF_TX     = 2'd2;
  localparam logic [OFF_W-1:0] OFF_RX     = 2'd3;

  typedef struct packed {
    logic grant;   // held privilege flag
    logic wrEn;    // granted register write
    logic rdOk;    // granted register read
    logic rdAny;   // any register read (granted or not)
  } gateStrobes_t;
endpackage

// File: rtl/spigate_ctrl.sv
module spigate_ctrl
  import spigate_pkg::*;
#(
  parameter int PREFIX_W = 2,
  parameter logic [PREFIX_W-1:0] ROM_PREFIX = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuValid,
  input  logic                cpuInstr,
  input  logic [PREFIX_W-1:0] fetchPrefix,
  input  logic                apiCs,
  input  logic                apiWe,
  output gateStrobes_t        strobes
);
  logic privQ;
  logic fetchCycle;

  assign fetchCycle = cpuValid && cpuInstr;

  always_ff @(posedge clk) begin
    if (!rstN) privQ <= 1'b1;
    else if (fetchCycle) privQ <= (fetchPrefix == ROM_PREFIX);
  end

  always_comb begin
    strobes.grant = privQ;
    strobes.wrEn  = apiCs && apiWe && privQ;
    strobes.rdOk  = apiCs && !apiWe && privQ;
    strobes.rdAny = apiCs && !apiWe;
  end

  assert_hold_on_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuValid && cpuInstr) |=> $stable(privQ));

  assert_fetch_decides_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuInstr && fetchPrefix != ROM_PREFIX) |=> !strobes.grant);
endmodule

// File: rtl/spigate_engine.sv
module spigate_engine #(
  parameter int XFER_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selWr,
  input  logic              selData,
  input  logic              txStart,
  input  logic [XFER_W-1:0] txData,
  input  logic              misoIn,
  output logic              idle,
  output logic              selEn,
  output logic [XFER_W-1:0] rxData,
  output logic              csNOut,
  output logic              sclkOut,
  output logic              mosiOut
);
  localparam int CNT_W = $clog2(XFER_W + 1);

  logic              busyQ;
  logic              sclkQ;
  logic              selQ;
  logic [CNT_W-1:0]  bitsLeftQ;
  logic [XFER_W-1:0] txShiftQ;
  logic [XFER_W-1:0] rxShiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= 1'b0;
    else if (selWr) selQ <= selData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      sclkQ     <= 1'b0;
      bitsLeftQ <= '0;
      txShiftQ  <= '0;
      rxShiftQ  <= '0;
    end else if (!busyQ) begin
      if (txStart) begin
        busyQ     <= 1'b1;
        sclkQ     <= 1'b0;
        bitsLeftQ <= CNT_W'(XFER_W);
        txShiftQ  <= txData;
      end
    end else if (!sclkQ) begin
      sclkQ    <= 1'b1;
      rxShiftQ <= {rxShiftQ[XFER_W-2:0], misoIn};
    end else begin
      sclkQ    <= 1'b0;
      txShiftQ <= {txShiftQ[XFER_W-2:0], 1'b0};
      if (bitsLeftQ == CNT_W'(1)) busyQ <= 1'b0;
      else bitsLeftQ <= bitsLeftQ - 1'b1;
    end
  end

  assign idle    = !busyQ;
  assign selEn   = selQ;
  assign rxData  = rxShiftQ;
  assign csNOut  = !selQ;
  assign sclkOut = sclkQ;
  assign mosiOut = busyQ && txShiftQ[XFER_W-1];

  assert_start_needs_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(txStart));

  assert_select_needs_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !selWr |=> $stable(selQ));
endmodule

// File: rtl/spigate_datapath.sv
module spigate_datapath
  import spigate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int XFER_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      strobes,
  input  logic              apiCs,
  input  logic [OFF_W-1:0]  apiAddr,
  input  logic [DATA_W-1:0] apiWrData,
  output logic [DATA_W-1:0] apiRdData,
  output logic              apiReady,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);
  logic              engIdle, engSel, engCsN, engSclk, engMosi, engMiso;
  logic [XFER_W-1:0] engRx;
  logic              selWr, txStart;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] rdDataQ;
  logic              readyQ;

  assign selWr   = strobes.wrEn && (apiAddr == OFF_SELECT);
  assign txStart = strobes.wrEn && (apiAddr == OFF_TX);
  assign engMiso = strobes.grant ? spiMiso : 1'b0;

  spigate_engine #(.XFER_W(XFER_W)) engine (
    .clk(clk), .rstN(rstN),
    .selWr(selWr), .selData(apiWrData[0]),
    .txStart(txStart), .txData(apiWrData[XFER_W-1:0]),
    .misoIn(engMiso),
    .idle(engIdle), .selEn(engSel), .rxData(engRx),
    .csNOut(engCsN), .sclkOut(engSclk), .mosiOut(engMosi)
  );

  always_comb begin
    rdWord = '0;
    unique case (apiAddr)
      OFF_STATUS: rdWord[0] = engIdle;
      OFF_SELECT: rdWord[0] = engSel;
      OFF_RX:     rdWord[XFER_W-1:0] = engRx;
      default:    rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ  <= 1'b0;
      rdDataQ <= '0;
    end else begin
      readyQ  <= apiCs;
      rdDataQ <= strobes.rdOk ? rdWord : '0;
    end
  end

  assign apiRdData = rdDataQ;
  assign apiReady  = readyQ;
  assign spiCsN    = strobes.grant ? engCsN  : 1'b1;
  assign spiSclk   = strobes.grant && engSclk;
  assign spiMosi   = strobes.grant && engMosi;

  assert_ack_next_R3: assert property (@(posedge clk) disable iff (!rstN)
    apiCs |=> apiReady);

  assert_denied_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdAny && !strobes.grant) |=> (apiRdData == '0));
endmodule

// File: rtl/spigate_top.sv
module spigate_top
  import spigate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int XFER_W = 8,
  parameter int PREFIX_W = 2,
  parameter logic [PREFIX_W-1:0] ROM_PREFIX = 2'b00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuInstr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              apiCs,
  input  logic              apiWe,
  input  logic [OFF_W-1:0]  apiAddr,
  input  logic [DATA_W-1:0] apiWrData,
  output logic [DATA_W-1:0] apiRdData,
  output logic              apiReady,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);
  gateStrobes_t strobes;

  spigate_ctrl #(.PREFIX_W(PREFIX_W), .ROM_PREFIX(ROM_PREFIX)) ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuInstr(cpuInstr),
    .fetchPrefix(cpuAddr[ADDR_W-1 -: PREFIX_W]),
    .apiCs(apiCs), .apiWe(apiWe),
    .strobes(strobes)
  );

  spigate_datapath #(.DATA_W(DATA_W), .XFER_W(XFER_W)) datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .apiCs(apiCs), .apiAddr(apiAddr), .apiWrData(apiWrData),
    .apiRdData(apiRdData), .apiReady(apiReady),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );
endmodule

// File: tb/spigate_top_test.sv
module spigate_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0, cpuInstr = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic        apiCs = 1'b0, apiWe = 1'b0;
  logic [1:0]  apiAddr = '0;
  logic [31:0] apiWrData = '0;
  logic [31:0] apiRdData;
  logic        apiReady, spiCsN, spiSclk, spiMosi;
  logic        spiMiso = 1'b0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spigate_top uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input logic v, input logic ins);
    @(negedge clk); cpuValid = v; cpuInstr = ins; cpuAddr = a;
    @(negedge clk); cpuValid = 0; cpuInstr = 0;
  endtask

  task automatic apiWrite(input logic [1:0] off, input logic [31:0] d, input string req);
    @(negedge clk); apiCs = 1; apiWe = 1; apiAddr = off; apiWrData = d;
    @(negedge clk); apiCs = 0; apiWe = 0;
    check(req, {31'b0, apiReady}, 32'd1);
  endtask

  task automatic apiRead(input logic [1:0] off, input logic [31:0] exp, input string req);
    @(negedge clk); apiCs = 1; apiWe = 0; apiAddr = off;
    @(negedge clk); apiCs = 0;
    check("R3", {31'b0, apiReady}, 32'd1);
    check(req, apiRdData, exp);
  endtask

  task automatic testReset();
    check("R7 reset csN", {31'b0, spiCsN}, 32'd1);
    check("R7 reset sclk", {31'b0, spiSclk}, 32'd0);
    check("R3 reset ready", {31'b0, apiReady}, 32'd0);
    apiRead(2'd0, 32'd1, "R2 granted after reset");
  endtask

  task automatic testGrantDeny();
    fetch(32'h0000_0100, 1, 1);
    apiWrite(2'd1, 32'd1, "R4 write ack");
    check("R4 csN low when enabled", {31'b0, spiCsN}, 32'd0);
    apiRead(2'd1, 32'd1, "R4 readback");
    fetch(32'h4000_0000, 1, 1);
    check("R7 csN forced high", {31'b0, spiCsN}, 32'd1);
    check("R7 mosi low", {31'b0, spiMosi}, 32'd0);
    apiRead(2'd0, 32'd0, "R6 status hidden");
    apiRead(2'd1, 32'd0, "R6 select hidden");
    apiWrite(2'd1, 32'd0, "R5 blocked write ack");
    fetch(32'h3FFF_FFFC, 1, 1);
    apiRead(2'd1, 32'd1, "R5 blocked write dropped");
    check("R4 csN low after regrant", {31'b0, spiCsN}, 32'd0);
  endtask

  task automatic testQualify();
    fetch(32'h8000_0000, 1, 1);
    fetch(32'h0000_0040, 1, 0);
    apiRead(2'd0, 32'd0, "R2 data cycle keeps deny");
    fetch(32'h0000_0040, 0, 1);
    apiRead(2'd0, 32'd0, "R1 invalid fetch ignored");
    fetch(32'h0000_0040, 1, 1);
    fetch(32'hC000_0000, 1, 0);
    apiRead(2'd0, 32'd1, "R1 ROM fetch grants, R2 data cycle keeps");
  endtask

  task automatic testTransfer();
    logic [7:0] mosiByte;
    int rises;
    logic prevSclk;
    spiMiso = 1;
    apiWrite(2'd2, 32'hA5, "R8 tx write");
    mosiByte = '0; rises = 0; prevSclk = spiSclk;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (spiSclk && !prevSclk) begin
        rises++;
        mosiByte = {mosiByte[6:0], spiMosi};
      end
      prevSclk = spiSclk;
    end
    check("R8 sclk pulses", rises, 32'd8);
    check("R8 mosi byte", {24'b0, mosiByte}, 32'hA5);
    apiRead(2'd3, 32'hFF, "R8 rx byte");
    apiWrite(2'd2, 32'h11, "R8 second tx");
    apiRead(2'd0, 32'd0, "R8 busy status");
    repeat (20) @(negedge clk);
    apiRead(2'd0, 32'd1, "R8 idle status");
  endtask

  task automatic testMisoGate();
    int bad;
    spiMiso = 1;
    @(negedge clk);
    apiCs = 1; apiWe = 1; apiAddr = 2'd2; apiWrData = 32'h3C;
    cpuValid = 1; cpuInstr = 1; cpuAddr = 32'h4000_1000;
    @(negedge clk);
    apiCs = 0; apiWe = 0; cpuValid = 0; cpuInstr = 0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (spiSclk || spiMosi || !spiCsN) bad++;
    end
    check("R7 pins idle while denied", bad, 32'd0);
    fetch(32'h0000_0200, 1, 1);
    apiRead(2'd3, 32'h00, "R7 miso gated");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        testReset();
        testGrantDeny();
        testQualify();
        testTransfer();
        testMisoGate();
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule